// File: doc/BRIEF.md
# Keyboard Interrupt Latch Controller

This block watches a bank of active-low key inputs and raises a single pending interrupt when an enabled key is pressed. Each key input is first resynchronised to the system clock. A per-key enable byte selects which keys may set the pending latch. A control byte chooses between two trigger sensitivities:

- **Edge mode:** only a falling edge on an enabled key sets the latch.
- **Level mode:** the latch is also set again on every clock while any enabled key is held low.

Software reads the pending flag, acknowledges it, and can mask the interrupt output. The latch itself keeps working while the output is masked.

A halted-system indication (`brk_i`) and a companion permit input (`brk_clr_en_i`) decide whether acknowledge writes take effect while the system is stopped:

- With the permit low, the latch is protected and acknowledge writes during the halt are ignored.
- With the permit high, acknowledge writes clear the latch during the halt, and the latch stays clear after the halt ends.

Registers are written through a simple single-cycle write strobe. Read data is returned combinationally from the address.

Top module: `kbd_irq_ctrl`

## Requirements
- R1: After reset, the control byte (address 0x1A) reads 0x00, the enable byte (address 0x1B) reads 0x00, and `irq_o` is 0.
- R2: The control byte reads `{4'b0, pend, 1'b0, mask, level_mode}`. Bit 3 is the pending flag, bit 2 is the acknowledge bit and always reads 0, bit 1 is the mask, and bit 0 selects level mode. Bits 7..4 always read 0. Bits 1 and 0 read back the last value written.
- R3: The enable byte is read/write, and bit i enables key i.
- R4: In edge mode (bit 0 = 0), a falling edge on an enabled key sets the pending flag 3 clocks after the key changes.
- R5: A key whose enable bit is 0 never sets the pending flag.
- R6: Writing the control byte with bit 2 = 1 clears the pending flag at the next clock. Writing bit 2 = 0 leaves it unchanged.
- R7: `irq_o` equals pending AND NOT mask. The pending flag stays readable while masked.
- R8: In level mode (bit 0 = 1), while any enabled key is held low, the pending flag is set on every clock, so an acknowledge does not clear it until the keys are released.
- R9: While `brk_i` = 1 and `brk_clr_en_i` = 0, acknowledge writes have no effect.
- R10: While `brk_i` = 1 and `brk_clr_en_i` = 1, an acknowledge clears the pending flag, and the flag stays 0 after `brk_i` returns to 0.
- R11: When a new key edge and an acknowledge fall in the same clock, the pending flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kbd_n_i | input | NUM_KEYS | Active-low key inputs (asynchronous) |
| brk_i | input | 1 | System halted (break) indication |
| brk_clr_en_i | input | 1 | Permits acknowledge during a halt |
| addr_i | input | ADDR_W | Register address |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
A key change reaches the pending flag after three clock edges: two synchroniser stages, then the latch. The bench therefore waits three rising edges after driving a key before it samples the flag. Register writes and acknowledges take effect at the single clock edge of the write strobe. Mask changes reach `irq_o` combinationally from the updated mask register on that same edge.

Inputs are driven on the falling clock edge, and outputs are sampled shortly after a falling edge. The same-cycle race (R11) is set up by issuing the acknowledge strobe exactly in the cycle that follows the second synchroniser edge, which is the cycle in which the new edge reaches the latch.

// File: rtl/kbd_irq_pkg.sv
package kbd_irq_pkg;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned BIT_PEND = 3;
    localparam int unsigned BIT_ACK  = 2;
    localparam int unsigned BIT_MASK = 1;
    localparam int unsigned BIT_MODE = 0;

    typedef struct packed {
        logic mask;
        logic level_mode;
    } kbd_ctrl_t;
endpackage

// File: rtl/kbd_sync.sv
module kbd_sync #(
    parameter int unsigned NUM_KEYS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_KEYS-1:0] pin_n,
    output logic [NUM_KEYS-1:0] pin_s
);
    typedef struct packed {
        logic stg1;
        logic stg2;
    } sync_t;

    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
        sync_t s_d, s_q;

        always_comb begin
            s_d      = s_q;
            s_d.stg1 = pin_n[k];
            s_d.stg2 = s_q.stg1;
        end

        // Idle level of an active-low key is high
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '{stg1: 1'b1, stg2: 1'b1};
            else        s_q <= s_d;
        end

        assign pin_s[k] = s_q.stg2;
    end
endmodule

// File: rtl/kbd_latch.sv
module kbd_latch #(
    parameter int unsigned NUM_KEYS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_KEYS-1:0] pin_s,
    input  logic [NUM_KEYS-1:0] key_en,
    input  logic                level_mode,
    input  logic                ack_req,
    input  logic                brk,
    input  logic                brk_clr_en,
    output logic                pend,
    output logic                set_hit
);
    typedef struct packed {
        logic [NUM_KEYS-1:0] prev;
        logic                pend;
    } lat_t;

    lat_t                lat_d, lat_q;
    logic [NUM_KEYS-1:0] fall;
    logic [NUM_KEYS-1:0] held_low;
    logic                ack_ok;

    always_comb begin
        fall     = lat_q.prev & ~pin_s & key_en;
        held_low = ~pin_s & key_en;
        set_hit  = level_mode ? (|held_low) : (|fall);
        ack_ok   = ack_req & (~brk | brk_clr_en);

        lat_d      = lat_q;
        lat_d.prev = pin_s;
        // A fresh set beats a simultaneous acknowledge
        lat_d.pend = set_hit | (lat_q.pend & ~ack_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '{prev: '1, pend: 1'b0};
        else        lat_q <= lat_d;
    end

    assign pend = lat_q.pend;
endmodule

// File: rtl/kbd_regs.sv
module kbd_regs
    import kbd_irq_pkg::*;
#(
    parameter int unsigned          NUM_KEYS  = 8,
    parameter int unsigned          ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]    CTRL_ADDR = 'h1A,
    parameter logic [ADDR_W-1:0]    EN_ADDR   = 'h1B
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                pend,
    output logic [DATA_W-1:0]   rdata,
    output logic                ack_req,
    output kbd_ctrl_t           ctrl,
    output logic [NUM_KEYS-1:0] key_en
);
    typedef struct packed {
        kbd_ctrl_t           ctrl;
        logic [NUM_KEYS-1:0] en;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  hit_ctrl, hit_en;

    always_comb begin
        hit_ctrl = (addr == CTRL_ADDR);
        hit_en   = (addr == EN_ADDR);
        ack_req  = wr_en & hit_ctrl & wdata[BIT_ACK];

        regs_d = regs_q;
        if (wr_en && hit_ctrl) begin
            regs_d.ctrl.mask       = wdata[BIT_MASK];
            regs_d.ctrl.level_mode = wdata[BIT_MODE];
        end
        if (wr_en && hit_en) begin
            regs_d.en = wdata[NUM_KEYS-1:0];
        end

        rdata = '0;
        if (hit_ctrl) begin
            rdata[BIT_PEND] = pend;
            rdata[BIT_MASK] = regs_q.ctrl.mask;
            rdata[BIT_MODE] = regs_q.ctrl.level_mode;
        end else if (hit_en) begin
            rdata[NUM_KEYS-1:0] = regs_q.en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign ctrl   = regs_q.ctrl;
    assign key_en = regs_q.en;
endmodule

// File: rtl/kbd_irq_ctrl.sv
module kbd_irq_ctrl
    import kbd_irq_pkg::*;
#(
    parameter int unsigned          NUM_KEYS  = 8,
    parameter int unsigned          ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]    CTRL_ADDR = 'h1A,
    parameter logic [ADDR_W-1:0]    EN_ADDR   = 'h1B
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_KEYS-1:0] kbd_n_i,
    input  logic                brk_i,
    input  logic                brk_clr_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                wr_en_i,
    input  logic [7:0]          wdata_i,
    output logic [7:0]          rdata_o,
    output logic                irq_o
);
    logic [NUM_KEYS-1:0] pin_s;
    logic [NUM_KEYS-1:0] key_en;
    kbd_ctrl_t           ctrl;
    logic                ack_req;
    logic                pend;
    logic                set_hit;
    logic                mask_w;

    kbd_sync #(.NUM_KEYS(NUM_KEYS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (kbd_n_i),
        .pin_s (pin_s)
    );

    kbd_regs #(
        .NUM_KEYS  (NUM_KEYS),
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .EN_ADDR   (EN_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr_i),
        .wr_en   (wr_en_i),
        .wdata   (wdata_i),
        .pend    (pend),
        .rdata   (rdata_o),
        .ack_req (ack_req),
        .ctrl    (ctrl),
        .key_en  (key_en)
    );

    kbd_latch #(.NUM_KEYS(NUM_KEYS)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_s      (pin_s),
        .key_en     (key_en),
        .level_mode (ctrl.level_mode),
        .ack_req    (ack_req),
        .brk        (brk_i),
        .brk_clr_en (brk_clr_en_i),
        .pend       (pend),
        .set_hit    (set_hit)
    );

    assign mask_w = ctrl.mask;
    assign irq_o  = pend & ~mask_w;
endmodule

// File: rtl/kbd_irq_chk.sv
module kbd_irq_chk #(
    parameter int unsigned       ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h1A
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_en_i,
    input logic [7:0]        wdata_i,
    input logic [7:0]        rdata_o,
    input logic              brk_i,
    input logic              brk_clr_en_i,
    input logic              irq_o,
    input logic              set_hit,
    input logic              pend
);
    logic ack_wr;
    assign ack_wr = wr_en_i && (addr_i == CTRL_ADDR) && wdata_i[2];

    assert_ctrl_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == CTRL_ADDR) |-> (rdata_o[7:4] == 4'h0 && rdata_o[2] == 1'b0));

    assert_set_latches_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_hit |=> pend);

    assert_rise_needs_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(set_hit));

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !brk_i && !set_hit) |=> !pend);

    assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == CTRL_ADDR && wdata_i[1]) |=> !irq_o);

    assert_brk_protect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_i && !brk_clr_en_i && pend) |=> pend);
endmodule

bind kbd_irq_ctrl kbd_irq_chk #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_i       (addr_i),
    .wr_en_i      (wr_en_i),
    .wdata_i      (wdata_i),
    .rdata_o      (rdata_o),
    .brk_i        (brk_i),
    .brk_clr_en_i (brk_clr_en_i),
    .irq_o        (irq_o),
    .set_hit      (set_hit),
    .pend         (pend)
);

// File: tb/kbd_irq_ctrl_bench.sv
module kbd_irq_ctrl_bench;
    localparam int unsigned CLK_PERIOD = 10;
    localparam logic [7:0]  A_CTRL     = 8'h1A;
    localparam logic [7:0]  A_EN       = 8'h1B;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] kbd_n = 8'hFF;
    logic       brk = 1'b0;
    logic       brk_clr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kbd_irq_ctrl u_kbd_irq_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .kbd_n_i      (kbd_n),
        .brk_i        (brk),
        .brk_clr_en_i (brk_clr_en),
        .addr_i       (addr),
        .wr_en_i      (wr_en),
        .wdata_i      (wdata),
        .rdata_o      (rdata),
        .irq_o        (irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pend_is(input string req, input logic exp);
        logic [7:0] v;
        rd(A_CTRL, v);
        check(req, {7'b0, v[3]}, {7'b0, exp});
    endtask

    // Return to idle: keys released, edge mode, unmasked, latch cleared
    task automatic idle();
        @(negedge clk);
        kbd_n = 8'hFF; brk = 1'b0; brk_clr_en = 1'b0;
        cycles(3);
        wr(A_CTRL, 8'h04);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(A_CTRL, v); check("R1 ctrl", v, 8'h00);
        rd(A_EN, v);   check("R1 en", v, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(A_CTRL, 8'hFF);
        rd(A_CTRL, v); check("R2 ctrl readback", v, 8'h03);
        wr(A_CTRL, 8'h00);
        rd(A_CTRL, v); check("R2 ctrl cleared", v, 8'h00);
        wr(A_EN, 8'hA5);
        rd(A_EN, v); check("R3 en readback", v, 8'hA5);
    endtask

    task automatic t_edge_and_disabled();
        logic [7:0] v;
        wr(A_EN, 8'h01);
        @(negedge clk); kbd_n = 8'hDF;      // key 5, disabled
        cycles(5);
        pend_is("R5 disabled key", 1'b0);
        check("R5 irq", {7'b0, irq}, 8'h00);
        @(negedge clk); kbd_n = 8'hDE;      // key 0 falls, enabled
        cycles(2);
        pend_is("R4 not yet after 2", 1'b0);
        cycles(1);
        pend_is("R4 set after 3", 1'b1);
        check("R4 irq", {7'b0, irq}, 8'h01);
        rd(A_CTRL, v); check("R2 pend layout", v, 8'h08);
        idle();
    endtask

    task automatic t_ack_and_mask();
        wr(A_EN, 8'h02);
        @(negedge clk); kbd_n = 8'hFD;
        cycles(3);
        wr(A_CTRL, 8'h02);                  // mask, no ack
        pend_is("R6 ack bit 0 keeps", 1'b1);
        check("R7 masked irq", {7'b0, irq}, 8'h00);
        wr(A_CTRL, 8'h00);
        check("R7 unmasked irq", {7'b0, irq}, 8'h01);
        wr(A_CTRL, 8'h04);
        pend_is("R6 ack clears", 1'b0);
        check("R6 irq after ack", {7'b0, irq}, 8'h00);
        idle();
    endtask

    task automatic t_level();
        wr(A_EN, 8'h04);
        wr(A_CTRL, 8'h01);
        @(negedge clk); kbd_n = 8'hFB;
        cycles(3);
        wr(A_CTRL, 8'h05);
        pend_is("R8 ack while held", 1'b1);
        @(negedge clk); kbd_n = 8'hFF;
        cycles(3);
        wr(A_CTRL, 8'h05);
        pend_is("R8 ack after release", 1'b0);
        wr(A_CTRL, 8'h00);
        idle();
    endtask

    task automatic t_break();
        wr(A_EN, 8'h08);
        @(negedge clk); kbd_n = 8'hF7;
        cycles(3);
        @(negedge clk); brk = 1'b1; brk_clr_en = 1'b0;
        wr(A_CTRL, 8'h04);
        pend_is("R9 protected in break", 1'b1);
        @(negedge clk); brk_clr_en = 1'b1;
        wr(A_CTRL, 8'h04);
        pend_is("R10 cleared in break", 1'b0);
        @(negedge clk); brk = 1'b0; brk_clr_en = 1'b0;
        cycles(3);
        pend_is("R10 stays clear", 1'b0);
        idle();
    endtask

    task automatic t_race();
        wr(A_EN, 8'h30);
        @(negedge clk); kbd_n = 8'hEF;      // key 4
        cycles(3);
        @(negedge clk); kbd_n = 8'hCF;      // key 5 falls
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        addr = A_CTRL; wdata = 8'h04; wr_en = 1'b1;   // ack on the set edge
        @(posedge clk);
        @(negedge clk); wr_en = 1'b0; #1;
        pend_is("R11 edge beats ack", 1'b1);
        wr(A_CTRL, 8'h04);
        pend_is("R6 later ack clears", 1'b0);
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 3);
        @(negedge clk); rst_n = 1'b1;
        #1;
        t_reset();
        t_regs();
        t_edge_and_disabled();
        t_ack_and_mask();
        t_level();
        t_break();
        t_race();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule